// File: doc/BRIEF.md
# Low-Power Run/Wait Mode Controller

This block decides, for a small microcontroller, whether the core runs with its on-chip regulator in full regulation or in loose regulation. The low-power modes it offers are ordinary run and wait with only the regulator setting changed. Every peripheral keeps its clock in those modes, so the low-power variants give full function at a reduced current ceiling.

Software asks for low power with a level request bit. The controller grants the request only while three things hold: the clock comes from an external source or the crystal oscillator, the CPU clock is no faster than a set ceiling, and the low-voltage detector is either disabled or enabled with its stop-enable bit clear. While loose regulation is active, the detector is powered down and the internal clock sources and bandgap reference are held off. If a condition breaks, or the request drops, the controller returns to full regulation. It then waits a fixed number of bus cycles with the CPU clock and the detector held off, and only after that reports normal mode again. A wait strobe gates the CPU clock and a wake interrupt ungates it. This works in both the normal and the low-power modes.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in normal run: `reg_loose_o`=0, `cpu_clk_en_o`=1, `ref_off_o`=0, `lvd_pwr_o` follows `lvd_en_i`, and `status_o`=0.
- R2: In normal run with no wait strobe, `lp_req_i`=1 and all entry conditions true at a clock edge, the block is in low-power run after that edge: `reg_loose_o`=1, `cpu_clk_en_o`=1, `status_o[0]`=1.
- R3: The clock-source condition is true only for `clk_src_i` codes 2'b01 (external clock) and 2'b10 (crystal oscillator). Codes 2'b00 and 2'b11 are internal sources and block entry.
- R4: The speed condition is true only when `SRC_KHZ >> clk_div_i` is at most `LP_MAX_KHZ` (250 kHz by default).
- R5: The detector condition is true when `lvd_en_i`=0 or `lvd_stop_en_i`=0.
- R6: A request seen in normal run while any condition is false leaves the block in normal mode and sets the sticky rejected bit `status_o[3]`, which stays set until reset.
- R7: `lvd_pwr_o` equals `lvd_en_i` in normal run and normal wait and is 0 in both low-power modes and while settling.
- R8: `ref_off_o` is 1 exactly while the regulator is in loose regulation.
- R9: In either low-power mode, a clock edge that sees `lp_req_i`=0 or any false condition returns the regulator to full regulation after that edge and starts settling (`status_o[2]`=1).
- R10: Settling lasts exactly `SETTLE_CYCLES` cycles with `cpu_clk_en_o`=0 and `lvd_pwr_o`=0. After that the block is in a normal mode.
- R11: A wait strobe in low-power run moves to low-power wait (`cpu_clk_en_o`=0, `status_o[1]`=1, regulator still loose). A wake interrupt there returns to low-power run.
- R12: In normal run a wait strobe moves to normal wait with the CPU clock gated. A wake there returns to normal run. A wait strobe takes priority over a request in the same cycle.
- R13: Settling that began in low-power wait ends in normal wait, unless a wake was seen at the exit edge or during settling, in which case it ends in normal run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req_i | input | 1 | Software request for loose regulation (level) |
| wait_i | input | 1 | Wait-instruction strobe |
| wake_i | input | 1 | Wake interrupt |
| clk_src_i | input | 2 | Clock-source select: 01 external, 10 crystal, 00/11 internal |
| clk_div_i | input | DIV_W | CPU clock divider exponent |
| lvd_en_i | input | 1 | Low-voltage detector enable bit |
| lvd_stop_en_i | input | 1 | Low-voltage detector stop-enable bit |
| reg_loose_o | output | 1 | Regulator in loose regulation |
| lvd_pwr_o | output | 1 | Low-voltage detector power enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| ref_off_o | output | 1 | Hold internal clocks and bandgap off |
| status_o | output | 4 | [0] low-power active, [1] CPU waiting, [2] settling, [3] request rejected |

## Verification
The bench builds the block with `SETTLE_CYCLES`=5, `SRC_KHZ`=4000, `LP_MAX_KHZ`=250 and `DIV_W`=3. A short settle window lets every exit path, including a wake that arrives mid-settle, be reached many times in a short run. With these frequency values, divider codes 3 and 4 sit on either side of the 250 kHz ceiling, so the boundary of the speed condition is tested directly. A behavioural model compares every output on every cycle. The stimulus walks through each entry condition, each exit cause from both low-power modes, and the priority of wait over request.

// File: rtl/lp_mode_pkg.sv
// Shared definitions for the low-power mode controller.
// Assumes: clock-source codes are fixed by the clock block that decodes them.
package lp_mode_pkg;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_WAIT    = 3'd1,
        PM_LP_RUN  = 3'd2,
        PM_LP_WAIT = 3'd3,
        PM_SETTLE  = 3'd4
    } pm_state_e;

    localparam logic [1:0] SRC_EXT  = 2'b01;
    localparam logic [1:0] SRC_XTAL = 2'b10;

endpackage

// File: rtl/lp_entry_gate.sv
// Evaluates whether loose regulation is currently permitted.
// Assumes: CPU clock = SRC_KHZ / 2**clk_div_i; purely combinational.
module lp_entry_gate #(
    parameter int unsigned SRC_KHZ    = 4000,
    parameter int unsigned LP_MAX_KHZ = 250,
    parameter int unsigned DIV_W      = 3
) (
    input  logic [1:0]       clk_src_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic             lvd_en_i,
    input  logic             lvd_stop_en_i,
    output logic             entry_ok_o
);
    import lp_mode_pkg::*;

    logic        src_ok;
    logic        speed_ok;
    logic        lvd_ok;
    logic [31:0] cpu_khz;

    // Combine source, speed and detector conditions (R3, R4, R5).
    always_comb begin
        src_ok     = (clk_src_i == SRC_EXT) || (clk_src_i == SRC_XTAL);
        cpu_khz    = 32'(SRC_KHZ) >> clk_div_i;
        speed_ok   = (cpu_khz <= 32'(LP_MAX_KHZ));
        lvd_ok     = !lvd_en_i || !lvd_stop_en_i;
        entry_ok_o = src_ok && speed_ok && lvd_ok;
    end

endmodule

// File: rtl/lp_settle_timer.sv
// Counts the settle window after leaving loose regulation.
// Assumes: load pulses on the edge that enters settling; SETTLE_CYCLES >= 1.
module lp_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic active_i,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window ends on the last settle cycle.
    always_comb done_o = active_i && (cnt_q == '0);

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_V) else $error("settle counter out of range"); // R10

endmodule

// File: rtl/lp_mode_fsm.sv
// Power-mode sequencer: normal/low-power run and wait, plus settle on exit.
// Assumes: entry_ok_i is combinational from current inputs; all inputs synchronous.
module lp_mode_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lp_req_i,
    input  logic                   wait_i,
    input  logic                   wake_i,
    input  logic                   entry_ok_i,
    input  logic                   settle_done_i,
    output logic                   settle_load_o,
    output lp_mode_pkg::pm_state_e state_o,
    output logic                   rejected_o
);
    import lp_mode_pkg::*;

    pm_state_e state_q, state_d;
    logic      ret_wait_q, ret_wait_d;
    logic      rejected_q, rejected_d;
    logic      lp_hold;

    // Next-state, return-target and rejection logic.
    always_comb begin
        state_d       = state_q;
        ret_wait_d    = ret_wait_q;
        rejected_d    = rejected_q;
        settle_load_o = 1'b0;
        lp_hold       = lp_req_i && entry_ok_i;
        unique case (state_q)
            PM_RUN: begin
                if (wait_i) begin
                    state_d = PM_WAIT;
                end else if (lp_req_i) begin
                    if (entry_ok_i) state_d = PM_LP_RUN;
                    else            rejected_d = 1'b1;
                end
            end
            PM_WAIT: begin
                if (wake_i) state_d = PM_RUN;
            end
            PM_LP_RUN: begin
                if (!lp_hold) begin
                    state_d       = PM_SETTLE;
                    ret_wait_d    = 1'b0;
                    settle_load_o = 1'b1;
                end else if (wait_i) begin
                    state_d = PM_LP_WAIT;
                end
            end
            PM_LP_WAIT: begin
                if (!lp_hold) begin
                    state_d       = PM_SETTLE;
                    ret_wait_d    = !wake_i;
                    settle_load_o = 1'b1;
                end else if (wake_i) begin
                    state_d = PM_LP_RUN;
                end
            end
            PM_SETTLE: begin
                ret_wait_d = ret_wait_q && !wake_i;
                if (settle_done_i) begin
                    state_d = (ret_wait_q && !wake_i) ? PM_WAIT : PM_RUN;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    // State registers with synchronous reset to normal run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PM_RUN;
            ret_wait_q <= 1'b0;
            rejected_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ret_wait_q <= ret_wait_d;
            rejected_q <= rejected_d;
        end
    end

    always_comb begin
        state_o    = state_q;
        rejected_o = rejected_q;
    end

    AST_LP_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_LP_RUN || state_q == PM_LP_WAIT) |-> $past(lp_req_i && entry_ok_i))
        else $error("low-power mode without permission"); // R2
    AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rejected_q) |-> rejected_q) else $error("rejected bit cleared"); // R6
    AST_LEAVE_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == PM_LP_RUN || state_q == PM_LP_WAIT)
         && !(state_q == PM_LP_RUN || state_q == PM_LP_WAIT)) |-> (state_q == PM_SETTLE))
        else $error("left loose regulation without settling"); // R9

endmodule

// File: rtl/lp_mode_ctrl.sv
// Top of the low-power run/wait controller: gates entry, sequences modes,
// times the settle window and drives regulator, detector and clock enables.
// Assumes: all inputs are synchronous to clk.
module lp_mode_ctrl #(
    parameter int unsigned SRC_KHZ       = 4000,
    parameter int unsigned LP_MAX_KHZ    = 250,
    parameter int unsigned DIV_W         = 3,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_req_i,
    input  logic             wait_i,
    input  logic             wake_i,
    input  logic [1:0]       clk_src_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic             lvd_en_i,
    input  logic             lvd_stop_en_i,
    output logic             reg_loose_o,
    output logic             lvd_pwr_o,
    output logic             cpu_clk_en_o,
    output logic             ref_off_o,
    output logic [3:0]       status_o
);
    import lp_mode_pkg::*;

    logic      entry_ok;
    logic      settle_load;
    logic      settle_done;
    logic      rejected;
    pm_state_e state;
    logic      in_lp;
    logic      in_settle;
    logic      in_wait;

    lp_entry_gate #(
        .SRC_KHZ    (SRC_KHZ),
        .LP_MAX_KHZ (LP_MAX_KHZ),
        .DIV_W      (DIV_W)
    ) u_gate (
        .clk_src_i     (clk_src_i),
        .clk_div_i     (clk_div_i),
        .lvd_en_i      (lvd_en_i),
        .lvd_stop_en_i (lvd_stop_en_i),
        .entry_ok_o    (entry_ok)
    );

    lp_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .lp_req_i      (lp_req_i),
        .wait_i        (wait_i),
        .wake_i        (wake_i),
        .entry_ok_i    (entry_ok),
        .settle_done_i (settle_done),
        .settle_load_o (settle_load),
        .state_o       (state),
        .rejected_o    (rejected)
    );

    lp_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (settle_load),
        .active_i (in_settle),
        .done_o   (settle_done)
    );

    // Decode the mode into regulator, detector, clock and status outputs.
    always_comb begin
        in_lp        = (state == PM_LP_RUN) || (state == PM_LP_WAIT);
        in_settle    = (state == PM_SETTLE);
        in_wait      = (state == PM_WAIT) || (state == PM_LP_WAIT);
        reg_loose_o  = in_lp;
        ref_off_o    = in_lp;
        cpu_clk_en_o = (state == PM_RUN) || (state == PM_LP_RUN);
        lvd_pwr_o    = lvd_en_i && ((state == PM_RUN) || (state == PM_WAIT));
        status_o     = {rejected, in_settle, in_wait, in_lp};
    end

    AST_LVD_OFF_LOOSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_loose_o |-> (!lvd_pwr_o && ref_off_o)) else $error("detector on in loose mode"); // R7
    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2] |-> (!cpu_clk_en_o && !lvd_pwr_o && !reg_loose_o))
        else $error("settle window not gated"); // R10
    AST_WAIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1] |-> !cpu_clk_en_o) else $error("CPU clock running in wait"); // R11

endmodule

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;
    localparam int SETTLE = 5;
    localparam int SRCK   = 4000;
    localparam int MAXK   = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0, wt = 1'b0, wake = 1'b0;
    logic [1:0] src = 2'b00;
    logic [2:0] dv = 3'd0;
    logic lvd_en = 1'b1, lvd_stop = 1'b1;
    logic reg_loose, lvd_pwr, cpu_en, ref_off;
    logic [3:0] status;

    int n_checks = 0;
    int n_err = 0;
    int cyc_cnt = 0;
    string cur_req = "R1";

    // Reference model state: 0 run, 1 wait, 2 lp run, 3 lp wait, 4 settle
    int m_st = 0, m_left = 0, m_ret = 0, m_rej = 0;

    always #2 clk = ~clk;

    lp_mode_ctrl #(.SRC_KHZ(SRCK), .LP_MAX_KHZ(MAXK), .DIV_W(3), .SETTLE_CYCLES(SETTLE)) u_lp_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .lp_req_i(lp_req), .wait_i(wt), .wake_i(wake),
        .clk_src_i(src), .clk_div_i(dv), .lvd_en_i(lvd_en), .lvd_stop_en_i(lvd_stop),
        .reg_loose_o(reg_loose), .lvd_pwr_o(lvd_pwr), .cpu_clk_en_o(cpu_en),
        .ref_off_o(ref_off), .status_o(status));

    function automatic int ok_now();
        int s_ok = (src == 2'b01 || src == 2'b10) ? 1 : 0;
        int f_ok = ((SRCK >> dv) <= MAXK) ? 1 : 0;
        int l_ok = (!lvd_en || !lvd_stop) ? 1 : 0;
        return s_ok & f_ok & l_ok;
    endfunction

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        cyc_cnt++;
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_ret = 0; m_rej = 0;
        end else begin
            case (m_st)
                0: if (wt) m_st = 1;
                   else if (lp_req) begin
                       if (ok_now() != 0) m_st = 2; else m_rej = 1;
                   end
                1: if (wake) m_st = 0;
                2: if (!(lp_req && ok_now() != 0)) begin m_st = 4; m_left = SETTLE; m_ret = 0; end
                   else if (wt) m_st = 3;
                3: if (!(lp_req && ok_now() != 0)) begin m_st = 4; m_left = SETTLE; m_ret = wake ? 0 : 1; end
                   else if (wake) m_st = 2;
                default: begin
                    if (wake) m_ret = 0;
                    if (m_left == 1) m_st = (m_ret != 0) ? 1 : 0;
                    else m_left--;
                end
            endcase
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // One cycle: compare all outputs against the model at the falling edge.
    task automatic cyc();
        int lp, e_status;
        @(negedge clk);
        lp = (m_st == 2 || m_st == 3) ? 1 : 0;
        e_status = (m_rej << 3) | ((m_st == 4 ? 1 : 0) << 2)
                 | ((m_st == 1 || m_st == 3 ? 1 : 0) << 1) | lp;
        chk("reg_loose", int'(reg_loose), lp);
        chk("ref_off", int'(ref_off), lp);
        chk("cpu_clk_en", int'(cpu_en), (m_st == 0 || m_st == 2) ? 1 : 0);
        chk("lvd_pwr", int'(lvd_pwr), (lvd_en && (m_st == 0 || m_st == 1)) ? 1 : 0);
        chk("status", int'(status), e_status);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_wait();
        wt = 1'b1; cyc(); wt = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; cyc(); wake = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        run(2);
        chk("R1 status after reset", int'(status), 0);

        // R6 and R3: request with an internal clock source is refused
        cur_req = "R6"; lp_req = 1'b1; src = 2'b00; dv = 3'd4; lvd_stop = 1'b0;
        run(3);
        chk("R6 rejected bit", int'(status[3]), 1);
        cur_req = "R3"; src = 2'b11; run(2);
        chk("R3 internal code 11 refused", int'(reg_loose), 0);

        // R4: divider 3 gives 500 kHz, too fast
        cur_req = "R4"; src = 2'b01; dv = 3'd3; run(3);
        chk("R4 too fast refused", int'(reg_loose), 0);

        // R5: detector enabled with stop-enable set blocks entry
        cur_req = "R5"; dv = 3'd4; lvd_stop = 1'b1; run(3);
        chk("R5 stop-enable refused", int'(reg_loose), 0);

        // R2, R7, R8: entry once all conditions hold
        cur_req = "R2"; lvd_stop = 1'b0; run(3);
        chk("R2 loose after entry", int'(reg_loose), 1);
        cur_req = "R7"; run(1);
        chk("R7 detector off in loose", int'(lvd_pwr), 0);

        // R11: wait and wake in low-power run
        cur_req = "R11"; pulse_wait(); run(2);
        chk("R11 cpu gated in lp wait", int'(cpu_en), 0);
        pulse_wake(); run(2);

        // R9 and R10: source goes internal, exit through settle
        cur_req = "R9"; src = 2'b00; run(2);
        cur_req = "R10"; run(SETTLE + 2);
        chk("R10 back to full regulation", int'(reg_loose), 0);

        // R3: crystal source allows re-entry
        cur_req = "R3"; src = 2'b10; run(3);
        chk("R3 crystal accepted", int'(reg_loose), 1);

        // R9: divider too fast during low-power run
        cur_req = "R9"; dv = 3'd2; run(SETTLE + 3);
        dv = 3'd5; run(3);

        // R13: request drops during low-power wait; settle ends in normal wait
        cur_req = "R13"; pulse_wait(); run(1);
        lp_req = 1'b0; run(SETTLE + 3);
        chk("R13 normal wait after settle", int'(status[1]), 1);
        pulse_wake(); run(2);

        // R13: wake during settle ends in normal run
        lp_req = 1'b1; run(2); pulse_wait(); run(1);
        lp_req = 1'b0; run(2); pulse_wake(); run(SETTLE + 2);
        chk("R13 run after wake in settle", int'(cpu_en), 1);

        // R13: wake on the exit edge itself
        lp_req = 1'b1; run(2); pulse_wait(); run(1);
        lp_req = 1'b0; wake = 1'b1; cyc(); wake = 1'b0; run(SETTLE + 2);

        // R12: normal wait/wake, and wait wins over a same-cycle request
        cur_req = "R12"; pulse_wait(); run(2);
        chk("R12 normal wait gated", int'(cpu_en), 0);
        pulse_wake(); run(1);
        lp_req = 1'b1; pulse_wait(); run(2);
        pulse_wake(); run(3);

        // R5: detector disabled allows entry even with stop-enable set; then stop-enable forces exit
        cur_req = "R5"; lvd_en = 1'b0; lvd_stop = 1'b1; run(3);
        lvd_en = 1'b1; run(SETTLE + 3);
        lvd_en = 1'b0; run(3);
        cur_req = "R7"; lvd_en = 1'b1; lvd_stop = 1'b0; run(3);
        lp_req = 1'b0; run(SETTLE + 3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc_cnt > 20000);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 20000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule